// File: doc/BRIEF.md
# External Interrupt Conversion Unit

This block collects a bank of external interrupt lines and hands each one to a downstream interrupt controller as a clean, active-high level. Software picks, per channel, whether the line is watched for a level or for a transition, and whether the active sense is high/rising or low/falling. Each input is first brought into the local clock domain through a multi-stage synchroniser. An event on it then sets a per-channel request latch. The latch holds until software writes a one to that channel's bit in the clear register.

Level requests are latched too, so a level channel stays requested after its input goes away. A clear issued while the level is still active has no lasting effect, because the level sets the latch again in the same cycle. A mask gates each latch towards the output. Requests still latch while masked and show up when the mask is lifted. Plain storage words for source selection and software interrupts sit in the same register window. They drive nothing.

The register interface is a single-cycle write strobe with a byte address and a combinational read of the addressed word. Bit n of every word belongs to channel n.

Top module: `ext_irq_conv`

## Requirements
- R1: After reset the mask word reads all ones, the polarity word reads all ones, the sense word reads zero, the source-select and software words read zero, both status words read zero and `irq_out` is zero.
- R2: Word offsets (byte address): mask 0x00, source select 0x04, masked status 0x08, raw status 0x0C, clear 0x10, polarity 0x14, sense 0x18, software 0x1C. The mask, source-select, polarity, sense and software words read back what was written. The clear word reads zero.
- R3: `irq_out[n]` is high exactly when channel n's request latch is set and mask bit n is 0. A mask bit of 1 blocks the channel.
- R4: The raw status word reports every latch regardless of mask. The masked status word reports the latches ANDed with the inverted mask.
- R5: Level channels (sense bit 0) latch while the input is at its active level (polarity bit 1 = high, 0 = low). The latch stays set after the input returns to idle. A clear written while the input is still active leaves the latch set.
- R6: Edge channels (sense bit 1) latch only on a transition: rising when the polarity bit is 1, falling when it is 0. A steady input, or a transition of the other direction, sets nothing.
- R7: Writing 1 to bit n of the clear word clears channel n's latch. Bits written as 0 leave their latches unchanged.
- R8: When an edge event and a clear of the same channel fall in the same clock cycle, the latch ends up set.
- R9: A request that occurs while its channel is masked is kept. It drives `irq_out` once the mask bit is cleared, unless it was cleared before that.
- R10: An input change is visible in the raw status after the third rising clock edge following it, and not after the second (two synchroniser stages plus the latch).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the addressed word (combinational) |
| irq_in | input | N_CH | External interrupt lines, asynchronous |
| irq_out | output | N_CH | Active-high requests to the downstream controller |

## Verification
The hardest case to reach from the ports is a clear landing in the very clock cycle in which a freshly synchronised edge sets the latch. The bench reaches it by counting edges. It changes the input on a falling clock edge and waits two more falling edges. It then issues the clear write, so that the write and the third rising edge, where the latch would set, coincide. The same edge counting places samples just before and just after that third rising edge, which pins down the synchroniser depth.

// File: rtl/ext_irq_conv_pkg.sv
package ext_irq_conv_pkg;

   // Register word index (byte address divided by four)
   typedef enum logic [2:0] {
      RG_MASK  = 3'd0,
      RG_SRC   = 3'd1,
      RG_PEND  = 3'd2,
      RG_RAW   = 3'd3,
      RG_CLR   = 3'd4,
      RG_POL   = 3'd5,
      RG_SENSE = 3'd6,
      RG_SOFT  = 3'd7
   } reg_idx_e;

   localparam int unsigned IDX_W = 3;

endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   initial begin
      if (STAGES < 2) $error("eic_sync: STAGES must be at least 2");
      if (WIDTH < 1)  $error("eic_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d_async;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= '0;
         else        stg[s] <= stg[s-1];
      end
   end

   assign q_sync = stg[STAGES-1];

endmodule

// File: rtl/eic_chan_core.sv
module eic_chan_core #(
   parameter int unsigned N_CH = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_CH-1:0] line_s,
   input  logic [N_CH-1:0] pol,
   input  logic [N_CH-1:0] sense,
   input  logic [N_CH-1:0] clr,
   output logic [N_CH-1:0] set_vec,
   output logic [N_CH-1:0] req_q
);

   logic [N_CH-1:0] line_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_d <= '0;
      else        line_d <= line_s;
   end

   for (genvar n = 0; n < N_CH; n++) begin : g_ch
      logic active_lvl;
      logic rise_evt;
      logic fall_evt;
      logic edge_evt;

      assign active_lvl = pol[n] ? line_s[n] : ~line_s[n];
      assign rise_evt   = line_s[n] & ~line_d[n];
      assign fall_evt   = ~line_s[n] & line_d[n];
      assign edge_evt   = pol[n] ? rise_evt : fall_evt;
      assign set_vec[n] = sense[n] ? edge_evt : active_lvl;

      // a new event dominates a clear in the same cycle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          req_q[n] <= 1'b0;
         else if (set_vec[n]) req_q[n] <= 1'b1;
         else if (clr[n])     req_q[n] <= 1'b0;
      end
   end

endmodule

// File: rtl/eic_regs.sv
module eic_regs
   import ext_irq_conv_pkg::*;
#(
   parameter int unsigned N_CH   = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [N_CH-1:0]   req_q,
   output logic [N_CH-1:0]   mask_q,
   output logic [N_CH-1:0]   pol_q,
   output logic [N_CH-1:0]   sense_q,
   output logic [N_CH-1:0]   clr_vec
);

   initial begin
      if (ADDR_W < IDX_W + 2) $error("eic_regs: ADDR_W too small for the register window");
      if (N_CH > DATA_W)      $error("eic_regs: N_CH exceeds DATA_W");
   end

   reg_idx_e        idx;
   logic [N_CH-1:0] wbits;
   logic [N_CH-1:0] src_q;
   logic [N_CH-1:0] soft_q;

   assign idx   = reg_idx_e'(bus_addr[IDX_W+1:2]);
   assign wbits = bus_wdata[N_CH-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '1;
         pol_q   <= '1;
         sense_q <= '0;
         src_q   <= '0;
         soft_q  <= '0;
      end else if (bus_wr) begin
         case (idx)
            RG_MASK:  mask_q  <= wbits;
            RG_SRC:   src_q   <= wbits;
            RG_POL:   pol_q   <= wbits;
            RG_SENSE: sense_q <= wbits;
            RG_SOFT:  soft_q  <= wbits;
            default:  ;
         endcase
      end
   end

   assign clr_vec = (bus_wr && idx == RG_CLR) ? wbits : '0;

   always_comb begin
      bus_rdata = '0;
      case (idx)
         RG_MASK:  bus_rdata[N_CH-1:0] = mask_q;
         RG_SRC:   bus_rdata[N_CH-1:0] = src_q;
         RG_PEND:  bus_rdata[N_CH-1:0] = req_q & ~mask_q;
         RG_RAW:   bus_rdata[N_CH-1:0] = req_q;
         RG_POL:   bus_rdata[N_CH-1:0] = pol_q;
         RG_SENSE: bus_rdata[N_CH-1:0] = sense_q;
         RG_SOFT:  bus_rdata[N_CH-1:0] = soft_q;
         default:  bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/ext_irq_conv.sv
module ext_irq_conv #(
   parameter int unsigned N_CH        = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [N_CH-1:0]   irq_in,
   output logic [N_CH-1:0]   irq_out
);

   initial begin
      if (N_CH < 1 || N_CH > DATA_W) $error("ext_irq_conv: N_CH out of range");
   end

   logic [N_CH-1:0] line_s;
   logic [N_CH-1:0] mask_q;
   logic [N_CH-1:0] pol_q;
   logic [N_CH-1:0] sense_q;
   logic [N_CH-1:0] clr_vec;
   logic [N_CH-1:0] set_vec;
   logic [N_CH-1:0] req_q;

   eic_sync #(.WIDTH(N_CH), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (irq_in),
      .q_sync  (line_s)
   );

   eic_chan_core #(.N_CH(N_CH)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_s  (line_s),
      .pol     (pol_q),
      .sense   (sense_q),
      .clr     (clr_vec),
      .set_vec (set_vec),
      .req_q   (req_q)
   );

   eic_regs #(.N_CH(N_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .req_q     (req_q),
      .mask_q    (mask_q),
      .pol_q     (pol_q),
      .sense_q   (sense_q),
      .clr_vec   (clr_vec)
   );

   assign irq_out = req_q & ~mask_q;

endmodule

// File: rtl/ext_irq_conv_chk.sv
module ext_irq_conv_chk #(
   parameter int unsigned N_CH = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic [N_CH-1:0] mask_q,
   input logic [N_CH-1:0] req_q,
   input logic [N_CH-1:0] set_vec,
   input logic [N_CH-1:0] clr_vec,
   input logic [N_CH-1:0] irq_out
);

   // R1
   reset_state_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (mask_q == '1 && req_q == '0 && irq_out == '0));

   // R5
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(req_q) & ~$past(clr_vec)) & ~req_q) == '0));

   // R8
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(set_vec) & ~req_q) == '0));

   // R7
   clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(clr_vec) & ~$past(set_vec)) & req_q) == '0));

   // R3
   out_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((irq_out & ~$past(irq_out)
                 & ~(req_q & ~$past(req_q))
                 & ~($past(mask_q) & ~mask_q)) == '0));

endmodule

bind ext_irq_conv ext_irq_conv_chk #(.N_CH(N_CH)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .mask_q  (mask_q),
   .req_q   (req_q),
   .set_vec (set_vec),
   .clr_vec (clr_vec),
   .irq_out (irq_out)
);

// File: tb/ext_irq_conv_tb.sv
`timescale 1ns/1ps
module ext_irq_conv_tb;

   localparam int unsigned N_CH   = 32;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned ADDR_W = 5;

   localparam logic [2:0] A_MASK  = 3'd0;
   localparam logic [2:0] A_SRC   = 3'd1;
   localparam logic [2:0] A_PEND  = 3'd2;
   localparam logic [2:0] A_RAW   = 3'd3;
   localparam logic [2:0] A_CLR   = 3'd4;
   localparam logic [2:0] A_POL   = 3'd5;
   localparam logic [2:0] A_SENSE = 3'd6;
   localparam logic [2:0] A_SOFT  = 3'd7;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic [N_CH-1:0]   irq_in = '0;
   logic [N_CH-1:0]   irq_out;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   ext_irq_conv #(.N_CH(N_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_in    (irq_in),
      .irq_out   (irq_out)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] idx, input logic [31:0] data);
      @(negedge clk);
      bus_wr    = 1'b1;
      bus_addr  = {idx, 2'b00};
      bus_wdata = data;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input logic [2:0] idx, output logic [31:0] data);
      bus_addr = {idx, 2'b00};
      #0.5;
      data = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R10 watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      rd(A_MASK, v);  check("R1 mask", v, 32'hFFFF_FFFF);
      rd(A_POL, v);   check("R1 polarity", v, 32'hFFFF_FFFF);
      rd(A_SENSE, v); check("R1 sense", v, 32'h0);
      rd(A_SRC, v);   check("R1 srcsel", v, 32'h0);
      rd(A_SOFT, v);  check("R1 soft", v, 32'h0);
      rd(A_RAW, v);   check("R1 raw", v, 32'h0);
      rd(A_PEND, v);  check("R1 pend", v, 32'h0);
      check("R1 irq_out", irq_out, 32'h0);

      // R2 readback of storage words and the write-only clear word
      wr(A_SRC, 32'hA5A5_0F0F);  rd(A_SRC, v);  check("R2 srcsel", v, 32'hA5A5_0F0F);
      wr(A_SOFT, 32'h1234_5678); rd(A_SOFT, v); check("R2 soft", v, 32'h1234_5678);
      rd(A_CLR, v); check("R2 clear reads zero", v, 32'h0);
      wr(A_MASK, 32'h0);
      rd(A_MASK, v); check("R2 mask", v, 32'h0);
      wr(A_SENSE, 32'hFFFF_FFFF);
      rd(A_SENSE, v); check("R2 sense", v, 32'hFFFF_FFFF);

      // Sweep every channel: rising edge, latency R10, output R3, hold R6, clear R7
      for (int c = 0; c < N_CH; c++) begin
         @(negedge clk); irq_in[c] = 1'b1;
         @(negedge clk);
         @(negedge clk); rd(A_RAW, v); check("R10 not before third edge", v, 32'h0);
         @(negedge clk); rd(A_RAW, v); check("R10 latched on third edge", v, 32'h1 << c);
         check("R3 irq_out channel", irq_out, 32'h1 << c);
         irq_in[c] = 1'b0;
         idle(3);
         rd(A_RAW, v); check("R6 edge held after release", v, 32'h1 << c);
         wr(A_CLR, 32'h1 << c);
         rd(A_RAW, v); check("R7 sweep clear", v, 32'h0);
      end

      // R7 zero bits have no effect
      irq_in[3] = 1'b1; irq_in[5] = 1'b1; idle(4);
      irq_in[3] = 1'b0; irq_in[5] = 1'b0; idle(3);
      wr(A_CLR, 32'h0);
      rd(A_RAW, v); check("R7 zero write keeps", v, 32'h28);
      wr(A_CLR, 32'h8);
      rd(A_RAW, v); check("R7 selective clear", v, 32'h20);
      wr(A_CLR, 32'h20);

      // R6 steady high does not relatch
      irq_in[7] = 1'b1; idle(4);
      wr(A_CLR, 32'h80); idle(4);
      rd(A_RAW, v); check("R6 steady high no relatch", v, 32'h0);
      irq_in[7] = 1'b0; idle(4);
      rd(A_RAW, v); check("R6 wrong direction ignored", v, 32'h0);

      // R6 falling edge
      wr(A_POL, ~(32'h1 << 9));
      irq_in[9] = 1'b1; idle(4);
      rd(A_RAW, v); check("R6 rising ignored on falling channel", v, 32'h0);
      irq_in[9] = 1'b0; idle(4);
      rd(A_RAW, v); check("R6 falling edge latched", v, 32'h200);
      wr(A_CLR, 32'h200);
      wr(A_POL, 32'hFFFF_FFFF);

      // R5 active-high level
      wr(A_SENSE, ~(32'h1 << 12));
      irq_in[12] = 1'b1; idle(4);
      rd(A_RAW, v); check("R5 level high latched", v, 32'h1000);
      wr(A_CLR, 32'h1000);
      rd(A_RAW, v); check("R5 clear ignored while active", v, 32'h1000);
      irq_in[12] = 1'b0; idle(4);
      rd(A_RAW, v); check("R5 sticky after release", v, 32'h1000);
      wr(A_CLR, 32'h1000);
      rd(A_RAW, v); check("R5 clear after release", v, 32'h0);

      // R5 active-low level
      irq_in[14] = 1'b1; idle(4);
      wr(A_POL, ~(32'h1 << 14));
      wr(A_SENSE, ~((32'h1 << 12) | (32'h1 << 14)));
      wr(A_CLR, 32'h4000);
      rd(A_RAW, v); check("R5 low level idle high", v, 32'h0);
      irq_in[14] = 1'b0; idle(4);
      rd(A_RAW, v); check("R5 low level latched", v, 32'h4000);
      irq_in[14] = 1'b1; idle(4);
      wr(A_CLR, 32'h4000);
      rd(A_RAW, v); check("R5 low level cleared", v, 32'h0);
      wr(A_SENSE, 32'hFFFF_FFFF);
      wr(A_POL, 32'hFFFF_FFFF);
      irq_in[14] = 1'b0; idle(4);
      wr(A_CLR, 32'hFFFF_FFFF);

      // R8 edge and clear in the same cycle
      @(negedge clk); irq_in[20] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = {A_CLR, 2'b00}; bus_wdata = 32'h1 << 20;
      @(negedge clk);
      bus_wr = 1'b0;
      rd(A_RAW, v); check("R8 edge beats clear", v, 32'h1 << 20);
      irq_in[20] = 1'b0; idle(3);
      wr(A_CLR, 32'h1 << 20);

      // R9 and R4 latching while masked
      wr(A_MASK, 32'hFFFF_FFFF);
      irq_in[25] = 1'b1; idle(4); irq_in[25] = 1'b0; idle(3);
      rd(A_RAW, v);  check("R4 raw ignores mask", v, 32'h1 << 25);
      rd(A_PEND, v); check("R4 masked status blocked", v, 32'h0);
      check("R3 masked output low", irq_out, 32'h0);
      wr(A_MASK, ~(32'h1 << 25));
      rd(A_PEND, v); check("R4 masked status after unmask", v, 32'h1 << 25);
      check("R9 pending appears on unmask", irq_out, 32'h1 << 25);
      wr(A_CLR, 32'h1 << 25);
      check("R3 output drops on clear", irq_out, 32'h0);
      wr(A_MASK, 32'hFFFF_FFFF);
      irq_in[26] = 1'b1; idle(4); irq_in[26] = 1'b0; idle(3);
      wr(A_CLR, 32'h1 << 26);
      wr(A_MASK, ~(32'h1 << 26));
      check("R9 cleared before unmask stays low", irq_out, 32'h0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule